// File: doc/BRIEF.md
# Linked Descriptor Chain Sequencer

This block sequences the transfers of one DMA channel. It works in one of two ways. In direct mode it takes a single transfer description from four configuration inputs and runs it. In chained mode it reads a list of descriptors from memory and runs them in turn. The list starts at the address given by the configuration `next` input. Every descriptor is four 32-bit words, stored in this order: device address (+0), memory address (+4), size (+8) and link (+12).

For every element, the sequencer raises a transfer request to an external data mover and holds it until the mover acknowledges. The request carries the device address, the current memory address and the element width. The sequencer reports its progress as a 2-bit state code. It also gives a one-cycle done pulse, a one-cycle interrupt pulse and a sticky error flag. A register block above it can latch these outputs.

Top module: `chain_dma_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: state code 0, no read request, no transfer request, and done, interrupt and error all low.
- R2: A start pulse with `mode_sg`=0 runs one descriptor taken directly from `cfg_dev_addr`, `cfg_mem_addr`, `cfg_size` and `cfg_next`, and issues no descriptor reads.
- R3: A start pulse with `mode_sg`=1 reads four words, in the order +0, +4, +8, +12, from `cfg_next` with its two low bits cleared. One word is read at a time.
- R4: Size bits [13:12] give the element width: 3 is 1 byte (`xfer_width`=0), 2 is 2 bytes (`xfer_width`=1) and 0 is 4 bytes (`xfer_width`=2). The memory address advances by the width in bytes after each acknowledged element. The device address does not change within a descriptor.
- R5: Size bits [11:0] give the element count. A count above 0x3FF for 1- or 2-byte width, above 0x7FF for 4-byte width, or a width code of 1 sets the error flag, pulses the interrupt, returns to idle without done and issues no transfer. The next start clears the error flag.
- R6: Bits [1:0] of the link word are the chain code. Code 0 ends without an interrupt. Code 1 ends with an interrupt. Code 2 follows the link. Code 3 pulses the interrupt and follows the link. The next descriptor address is the link word with bits [1:0] cleared. In direct mode the link is never followed, and bit 0 alone decides the interrupt.
- R7: The state code is 0 when idle, 1 while descriptor words are read, 2 while a transfer request waits for its acknowledge, and 3 otherwise while busy.
- R8: A transfer request stays high, with its address and width fields stable, until it is acknowledged.
- R9: When a chain ends without error, done pulses for exactly one cycle. The state code is already 0 in that cycle.
- R10: An abort returns the block to idle on the next cycle and drops all requests. It raises neither done nor an interrupt.
- R11: A start pulse while the block is busy is ignored.
- R12: A count of 0 moves no elements. The chain code is then handled as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| mode_sg | input | 1 | 1 = chained descriptors, 0 = direct transfer |
| abort | input | 1 | Stop at once and return to idle |
| cfg_dev_addr | input | 32 | Direct-mode device address |
| cfg_mem_addr | input | 32 | Direct-mode memory address |
| cfg_size | input | 32 | Direct-mode size word (width and count) |
| cfg_next | input | 32 | Link word; in chained mode, the first descriptor address |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Byte address of the word being read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| xfer_req | output | 1 | Element transfer request |
| xfer_dev_addr | output | 32 | Device address of the element |
| xfer_mem_addr | output | 32 | Memory address of the element |
| xfer_width | output | 2 | log2 of the element size in bytes |
| xfer_ack | input | 1 | Element acknowledge |
| state_o | output | 2 | Progress state code |
| done_o | output | 1 | One-cycle chain-complete pulse |
| irq_o | output | 1 | One-cycle interrupt pulse |
| err_o | output | 1 | Sticky descriptor error flag |

## Verification
The bench runs a two-descriptor chain whose first link carries a follow-with-interrupt code. A design that stopped there, or that failed to clear the link's low bits, would fetch from the wrong words or lose the second descriptor. Counts are tried exactly at the 4-byte limit and just over the 1-byte limit, together with the forbidden width code. An off-by-one limit would flag a legal descriptor or run an illegal one. A count of zero, an abort in mid-transfer, a start while busy and a slow acknowledge each probe one failure: a counter underflow, a stray done pulse, a reloaded descriptor, or a request whose address moves before it is accepted.

// File: rtl/chain_dma_pkg.sv
// Shared types and helpers for the descriptor chain sequencer.
// Assumes 32-bit descriptor words and the 2-bit width/chain encodings of the brief.
package chain_dma_pkg;

    // Externally visible progress codes; values are seen by the register block.
    typedef enum logic [1:0] {
        STAT_IDLE   = 2'd0,
        STAT_DESC   = 2'd1,
        STAT_WAIT   = 2'd2,
        STAT_ACCESS = 2'd3
    } stat_e;

    // Internal sequencer phases.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_CHECK,
        PH_STEP,
        PH_WAIT
    } phase_e;

    // Width code from the size word mapped to log2 of the element bytes.
    function automatic logic [1:0] width_log2(input logic [1:0] code);
        case (code)
            2'd3:    return 2'd0;
            2'd2:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/chain_word_fetch.sv
// Reads the four words of one descriptor, one request at a time, from a base
// address aligned down to a word. Assumes the memory answers each held
// request with one rd_valid cycle. The words stay stored until the next fetch.
module chain_word_fetch #(
    parameter int WORD_W = 32,
    parameter int N_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              go,
    input  logic [WORD_W-1:0] base,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              fetch_done,
    output logic [WORD_W-1:0] words [N_WORDS]
);
    localparam int IDX_W = $clog2(N_WORDS);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [WORD_W-1:0] base_q;

    // Sequence control: start on go, advance the index on each returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
        end else if (abort) begin
            active <= 1'b0;
        end else if (go) begin
            active <= 1'b1;
            idx    <= '0;
            base_q <= {base[WORD_W-1:2], 2'b00};
        end else if (active && rd_valid) begin
            idx <= idx + 1'b1;
            if (idx == IDX_W'(N_WORDS - 1)) active <= 1'b0;
        end
    end

    // One storage register per descriptor word.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                                  words[g] <= '0;
            else if (active && rd_valid && idx == IDX_W'(g)) words[g] <= rd_data;
        end
    end

    assign rd_req     = active;
    assign rd_addr    = base_q + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};
    assign fetch_done = active && rd_valid && (idx == IDX_W'(N_WORDS - 1));

endmodule

// File: rtl/chain_desc_check.sv
// Decodes the size word into count and width, and flags a descriptor whose
// width code is reserved or whose count exceeds that width's maximum.
// Purely combinational; the caller decides when the result is used.
module chain_desc_check
    import chain_dma_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int MAX_NARROW = 1023,
    parameter int MAX_WIDE   = 2047
) (
    input  logic [13:0]      size_field,
    output logic [CNT_W-1:0] count,
    output logic [1:0]       wlog,
    output logic             bad
);
    logic [1:0]       wcode;
    logic [CNT_W-1:0] limit;

    // Split fields and pick the limit for the width.
    always_comb begin
        wcode = size_field[13:12];
        count = size_field[CNT_W-1:0];
        wlog  = width_log2(wcode);
        limit = (wcode == 2'd0) ? CNT_W'(MAX_WIDE) : CNT_W'(MAX_NARROW);
        bad   = (wcode == 2'd1) || (count > limit);
    end

endmodule

// File: rtl/chain_elem_ctr.sv
// Holds the current memory address and the remaining element count of the
// active descriptor; each step advances the address by the element size.
module chain_elem_ctr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_mem,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic [1:0]        load_wlog,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        wlog,
    output logic              rem_zero
);
    logic [CNT_W-1:0]  remaining;
    logic [ADDR_W-1:0] step_bytes;

    assign step_bytes = {{(ADDR_W-1){1'b0}}, 1'b1} << wlog;

    // Load a new descriptor or advance one element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            remaining <= '0;
            wlog      <= '0;
        end else if (load) begin
            mem_addr  <= load_mem;
            remaining <= load_cnt;
            wlog      <= load_wlog;
        end else if (step) begin
            mem_addr  <= mem_addr + step_bytes;
            remaining <= remaining - 1'b1;
        end
    end

    assign rem_zero = (remaining == '0);

endmodule

// File: rtl/chain_dma_seq.sv
// Per-channel sequencer: runs one directly configured descriptor or walks a
// linked descriptor list, issuing one element request at a time.
// Assumes a data mover that acknowledges each held request once, and a read
// port that returns one word per held read request.
module chain_dma_seq
    import chain_dma_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int CNT_W      = 12,
    parameter int MAX_NARROW = 1023,
    parameter int MAX_WIDE   = 2047
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_sg,
    input  logic              abort,
    input  logic [WORD_W-1:0] cfg_dev_addr,
    input  logic [WORD_W-1:0] cfg_mem_addr,
    input  logic [WORD_W-1:0] cfg_size,
    input  logic [WORD_W-1:0] cfg_next,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              xfer_req,
    output logic [WORD_W-1:0] xfer_dev_addr,
    output logic [WORD_W-1:0] xfer_mem_addr,
    output logic [1:0]        xfer_width,
    input  logic              xfer_ack,
    output logic [1:0]        state_o,
    output logic              done_o,
    output logic              irq_o,
    output logic              err_o
);
    localparam int N_WORDS = 4;

    phase_e            phase;
    logic              sg_q;
    logic [WORD_W-1:0] dev_q;
    logic [WORD_W-1:0] link_q;

    logic [WORD_W-1:0] fwords [N_WORDS];
    logic              fetch_done;
    logic              fetch_go;
    logic [WORD_W-1:0] fetch_base;

    logic [WORD_W-1:0] src_dev, src_mem, src_size, src_link;
    logic [CNT_W-1:0]  chk_count;
    logic [1:0]        chk_wlog;
    logic              chk_bad;
    logic              size_hi_unused;

    logic              ctr_load, ctr_step, rem_zero;
    logic              follow;

    // Descriptor source: fetched words in chained mode, inputs otherwise.
    always_comb begin
        if (sg_q) begin
            src_dev  = fwords[0];
            src_mem  = fwords[1];
            src_size = fwords[2];
            src_link = fwords[3];
        end else begin
            src_dev  = cfg_dev_addr;
            src_mem  = cfg_mem_addr;
            src_size = cfg_size;
            src_link = cfg_next;
        end
    end
    assign size_hi_unused = ^src_size[WORD_W-1:14];

    assign follow   = sg_q && link_q[1];
    assign fetch_go = !abort &&
                      ((phase == PH_IDLE && start && mode_sg) ||
                       (phase == PH_STEP && rem_zero && follow));
    assign fetch_base = (phase == PH_IDLE) ? cfg_next : link_q;
    assign ctr_load   = !abort && phase == PH_CHECK && !chk_bad;
    assign ctr_step   = !abort && phase == PH_WAIT && xfer_ack;

    chain_word_fetch #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) i_fetch (
        .clk(clk), .rst_n(rst_n), .abort(abort), .go(fetch_go), .base(fetch_base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .fetch_done(fetch_done), .words(fwords)
    );

    chain_desc_check #(.CNT_W(CNT_W), .MAX_NARROW(MAX_NARROW), .MAX_WIDE(MAX_WIDE)) i_check (
        .size_field(src_size[13:0]), .count(chk_count), .wlog(chk_wlog), .bad(chk_bad)
    );

    chain_elem_ctr #(.ADDR_W(WORD_W), .CNT_W(CNT_W)) i_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .step(ctr_step),
        .load_mem(src_mem), .load_cnt(chk_count), .load_wlog(chk_wlog),
        .mem_addr(xfer_mem_addr), .wlog(xfer_width), .rem_zero(rem_zero)
    );

    // Main phase sequencer with registered done, interrupt and error outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            sg_q   <= 1'b0;
            dev_q  <= '0;
            link_q <= '0;
            done_o <= 1'b0;
            irq_o  <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            irq_o  <= 1'b0;
            if (abort) begin
                phase <= PH_IDLE;
            end else begin
                case (phase)
                    PH_IDLE: if (start) begin
                        sg_q  <= mode_sg;
                        err_o <= 1'b0;
                        phase <= mode_sg ? PH_FETCH : PH_CHECK;
                    end
                    PH_FETCH: if (fetch_done) phase <= PH_CHECK;
                    PH_CHECK: if (chk_bad) begin
                        err_o <= 1'b1;
                        irq_o <= 1'b1;
                        phase <= PH_IDLE;
                    end else begin
                        dev_q  <= src_dev;
                        link_q <= src_link;
                        phase  <= PH_STEP;
                    end
                    PH_STEP: if (!rem_zero) begin
                        phase <= PH_WAIT;
                    end else if (follow) begin
                        irq_o <= link_q[0];
                        phase <= PH_FETCH;
                    end else begin
                        done_o <= 1'b1;
                        irq_o  <= link_q[0];
                        phase  <= PH_IDLE;
                    end
                    PH_WAIT: if (xfer_ack) phase <= PH_STEP;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // External state code derived from the phase.
    always_comb begin
        case (phase)
            PH_IDLE:  state_o = STAT_IDLE;
            PH_FETCH: state_o = STAT_DESC;
            PH_WAIT:  state_o = STAT_WAIT;
            default:  state_o = STAT_ACCESS;
        endcase
    end

    assign xfer_req      = (phase == PH_WAIT);
    assign xfer_dev_addr = dev_q;

endmodule

// File: rtl/chain_dma_seq_chk.sv
// Protocol and sequencing properties for chain_dma_seq, attached by bind.
module chain_dma_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        abort,
    input logic        rd_req,
    input logic        xfer_req,
    input logic        xfer_ack,
    input logic [31:0] xfer_dev_addr,
    input logic [31:0] xfer_mem_addr,
    input logic [1:0]  xfer_width,
    input logic [1:0]  state_o,
    input logic        done_o,
    input logic        irq_o,
    input logic        err_o
);
    // R1: reset leaves the block idle and silent.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (state_o == 2'd0 && !rd_req && !xfer_req && !done_o && !irq_o && !err_o));

    // R7: descriptor reads only in state 1.
    p_fetch_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> state_o == 2'd1);

    // R7: outstanding transfer only in state 2.
    p_wait_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> state_o == 2'd2);

    // R8: request held with stable fields until acknowledged.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack && !abort) |=>
        (xfer_req && $stable(xfer_mem_addr) && $stable(xfer_dev_addr) && $stable(xfer_width)));

    // R4: memory address steps by the element size after an acknowledge.
    p_mem_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && !abort) |=>
        (xfer_mem_addr == $past(xfer_mem_addr) + (32'd1 << $past(xfer_width))));

    // R10: abort lands in idle with no completion events.
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_o == 2'd0 && !done_o && !irq_o && !xfer_req && !rd_req));

    // R9: done is seen only in idle and never alongside an error.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_o == 2'd0 && !err_o));

    // R5: a detected error raises the interrupt and never done.
    p_err_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (irq_o && !done_o && state_o == 2'd0));

endmodule

bind chain_dma_seq chain_dma_seq_chk i_chk (.*);

// File: tb/test_chain_dma_seq.sv
module test_chain_dma_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, mode_sg = 1'b0, abort = 1'b0;
    logic [31:0] cfg_dev_addr = '0, cfg_mem_addr = '0, cfg_size = '0, cfg_next = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        xfer_req;
    logic [31:0] xfer_dev_addr, xfer_mem_addr;
    logic [1:0]  xfer_width;
    logic        xfer_ack = 1'b0;
    logic [1:0]  state_o;
    logic        done_o, irq_o, err_o;

    int n_chk = 0, n_err = 0;
    int ack_delay = 0, wcnt = 0;
    logic [31:0] mem [64];

    // monitor logs
    int n_el = 0, n_rd = 0, n_done = 0, n_irq = 0, n_fst = 0, n_hold_bad = 0;
    logic [31:0] el_mem [64];
    logic [31:0] el_dev [64];
    logic [1:0]  el_w   [64];
    logic [31:0] rd_log [64];
    logic [31:0] last_mem = '0;
    logic        pend = 1'b0;
    logic [31:0] pmem = '0, pdev = '0;
    logic [1:0]  pw = '0;

    chain_dma_seq i_chain_dma_seq (.*);

    always #4 clk = ~clk;

    // memory read model: one valid cycle per held request
    always @(posedge clk) begin
        rd_valid <= rd_req && !rd_valid;
        rd_data  <= mem[rd_addr[7:2]];
    end

    // data mover model with programmable acknowledge delay
    always @(posedge clk) begin
        if (xfer_req && !xfer_ack) begin
            if (wcnt >= ack_delay) begin xfer_ack <= 1'b1; wcnt <= 0; end
            else wcnt <= wcnt + 1;
        end else xfer_ack <= 1'b0;
    end

    // observation logs
    always @(posedge clk) begin
        if (xfer_req && xfer_ack) begin
            el_mem[n_el % 64] <= xfer_mem_addr;
            el_dev[n_el % 64] <= xfer_dev_addr;
            el_w[n_el % 64]   <= xfer_width;
            last_mem <= xfer_mem_addr;
            n_el <= n_el + 1;
        end
        if (rd_req && rd_valid) begin
            rd_log[n_rd % 64] <= rd_addr;
            n_rd <= n_rd + 1;
        end
        if (done_o) n_done <= n_done + 1;
        if (irq_o)  n_irq  <= n_irq + 1;
        if (rd_req && state_o == 2'd1) n_fst <= n_fst + 1;
        if (pend && xfer_req && (xfer_mem_addr != pmem || xfer_dev_addr != pdev || xfer_width != pw))
            n_hold_bad <= n_hold_bad + 1;
        pend <= xfer_req && !xfer_ack;
        pmem <= xfer_mem_addr; pdev <= xfer_dev_addr; pw <= xfer_width;
    end

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic sg, input logic [31:0] dv, mm, sz, nx);
        @(negedge clk);
        mode_sg = sg; cfg_dev_addr = dv; cfg_mem_addr = mm; cfg_size = sz; cfg_next = nx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (state_o == 2'd0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check_eq("R1", "state", state_o, 0);
        check_eq("R1", "requests", {rd_req, xfer_req}, 0);
        check_eq("R1", "flags", {done_o, irq_o, err_o}, 0);
    endtask

    task automatic t_oneshot_bytes();
        int e0 = n_el, r0 = n_rd, d0 = n_done, i0 = n_irq;
        pulse_start(1'b0, 32'h1000, 32'h2000, (32'd3 << 12) | 32'd3, 32'd1);
        wait_idle();
        check_eq("R2", "elements", n_el - e0, 3);
        check_eq("R2", "descriptor reads", n_rd - r0, 0);
        for (int k = 0; k < 3; k++) begin
            check_eq("R4", "1B mem addr", el_mem[(e0 + k) % 64], 32'h2000 + k);
            check_eq("R4", "1B dev addr", el_dev[(e0 + k) % 64], 32'h1000);
            check_eq("R4", "1B width", el_w[(e0 + k) % 64], 0);
        end
        check_eq("R9", "done pulses", n_done - d0, 1);
        check_eq("R6", "end-with-irq", n_irq - i0, 1);
    endtask

    task automatic t_chain();
        int e0 = n_el, r0 = n_rd, d0 = n_done, i0 = n_irq, f0 = n_fst;
        logic [31:0] exp_rd [8] = '{32'h40, 32'h44, 32'h48, 32'h4C, 32'h80, 32'h84, 32'h88, 32'h8C};
        logic [31:0] exp_m  [4] = '{32'h3000, 32'h3002, 32'h5000, 32'h5004};
        logic [31:0] exp_d  [4] = '{32'hA000, 32'hA000, 32'hB000, 32'hB000};
        logic [1:0]  exp_w  [4] = '{2'd1, 2'd1, 2'd2, 2'd2};
        pulse_start(1'b1, 32'h0, 32'h0, 32'h0, 32'h42);
        wait_idle();
        check_eq("R3", "descriptor reads", n_rd - r0, 8);
        for (int k = 0; k < 8; k++)
            check_eq("R3", "read address", rd_log[(r0 + k) % 64], exp_rd[k]);
        check_eq("R7", "fetch shown as state 1", (n_fst - f0) > 0, 1);
        check_eq("R6", "elements across link", n_el - e0, 4);
        for (int k = 0; k < 4; k++) begin
            check_eq("R4", "chain mem addr", el_mem[(e0 + k) % 64], exp_m[k]);
            check_eq("R4", "chain dev addr", el_dev[(e0 + k) % 64], exp_d[k]);
            check_eq("R4", "chain width", el_w[(e0 + k) % 64], exp_w[k]);
        end
        check_eq("R6", "follow-with-irq pulses", n_irq - i0, 1);
        check_eq("R9", "chain done", n_done - d0, 1);
    endtask

    task automatic t_slow_ack();
        int e0 = n_el, h0 = n_hold_bad, i0 = n_irq;
        ack_delay = 3;
        pulse_start(1'b0, 32'h7, 32'h100, (32'd2 << 12) | 32'd2, 32'd0);
        wait_idle();
        ack_delay = 0;
        check_eq("R8", "held fields changed", n_hold_bad - h0, 0);
        check_eq("R8", "elements", n_el - e0, 2);
        check_eq("R4", "2B second addr", el_mem[(e0 + 1) % 64], 32'h102);
        check_eq("R6", "end without irq", n_irq - i0, 0);
    endtask

    task automatic t_max_count();
        int e0 = n_el, d0 = n_done;
        pulse_start(1'b0, 32'h9, 32'h10000, 32'h7FF, 32'd0);
        wait_idle();
        check_eq("R5", "4B max count runs", n_el - e0, 2047);
        check_eq("R5", "4B max last addr", last_mem, 32'h11FF8);
        check_eq("R5", "no error at limit", err_o, 0);
        check_eq("R9", "done at limit", n_done - d0, 1);
    endtask

    task automatic t_bad_desc(input logic [31:0] sz, input string what);
        int e0 = n_el, d0 = n_done, i0 = n_irq;
        pulse_start(1'b0, 32'h1, 32'h200, sz, 32'd0);
        wait_idle();
        check_eq("R5", {what, " error flag"}, err_o, 1);
        check_eq("R5", {what, " irq"}, n_irq - i0, 1);
        check_eq("R5", {what, " no done"}, n_done - d0, 0);
        check_eq("R5", {what, " no elements"}, n_el - e0, 0);
    endtask

    task automatic t_zero_count();
        int e0 = n_el, d0 = n_done, i0 = n_irq;
        pulse_start(1'b0, 32'h1, 32'h300, 32'h0, 32'd0);
        wait_idle();
        check_eq("R5", "error cleared by start", err_o, 0);
        check_eq("R12", "zero count elements", n_el - e0, 0);
        check_eq("R12", "zero count done", n_done - d0, 1);
        check_eq("R12", "zero count irq", n_irq - i0, 0);
    endtask

    task automatic t_abort();
        int e0 = n_el, d0 = n_done, i0 = n_irq;
        pulse_start(1'b0, 32'h5, 32'h400, 32'd100, 32'd1);
        repeat (10) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check_eq("R10", "state after abort", state_o, 0);
        check_eq("R10", "request after abort", xfer_req, 0);
        repeat (5) @(negedge clk);
        check_eq("R10", "no done", n_done - d0, 0);
        check_eq("R10", "no irq", n_irq - i0, 0);
        check_eq("R10", "stopped early", (n_el - e0) < 100, 1);
    endtask

    task automatic t_start_busy();
        int e0 = n_el, r0 = n_rd, d0 = n_done;
        pulse_start(1'b0, 32'h1, 32'h600, (32'd3 << 12) | 32'd4, 32'd0);
        repeat (2) @(negedge clk);
        pulse_start(1'b1, 32'h0, 32'h0, 32'h0, 32'h40);
        wait_idle();
        check_eq("R11", "elements of first only", n_el - e0, 4);
        check_eq("R11", "no reads from ignored start", n_rd - r0, 0);
        check_eq("R11", "single done", n_done - d0, 1);
    endtask

    task automatic t_oneshot_follow();
        int r0 = n_rd, d0 = n_done, i0 = n_irq;
        pulse_start(1'b0, 32'h1, 32'h700, (32'd3 << 12) | 32'd1, 32'h43);
        wait_idle();
        check_eq("R6", "direct mode never follows", n_rd - r0, 0);
        check_eq("R6", "direct mode irq from bit0", n_irq - i0, 1);
        check_eq("R6", "direct mode done", n_done - d0, 1);
    endtask

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = '0;
        mem[16] = 32'hA000; mem[17] = 32'h3000; mem[18] = (32'd2 << 12) | 32'd2; mem[19] = 32'h83;
        mem[32] = 32'hB000; mem[33] = 32'h5000; mem[34] = 32'd2;                 mem[35] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot_bytes();
        t_chain();
        t_slow_ack();
        t_max_count();
        t_bad_desc((32'd3 << 12) | 32'h400, "1B over limit");
        t_bad_desc((32'd1 << 12) | 32'd1, "reserved width");
        t_zero_count();
        t_abort();
        t_start_busy();
        t_oneshot_follow();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule